// File: doc/BRIEF.md
# Key-Protected Memory Map Select Register

This block is a byte-wide configuration register on a simple CPU write/read bus. It chooses how a 20-bit physical address space is split between an on-chip ROM window, an on-chip RAM window and external space. To guard against stray stores, the register only takes a new value when that value arrives as the very next bus write after an unlock key has been written to the register's own address.

The block presents the stored 3-bit selection code. For any address placed on a probe port, it also presents three decode flags: internal ROM, internal RAM or external. The flags are purely combinational, so an address decoder or chip-select generator can use them in the same cycle. The selection applies the same way in every operating mode of the host chip. The block has no notion of single-chip or expanded operation.

A small two-state machine handles the unlock. The states are LOCKED and ARMED.
- LOCKED goes to ARMED (transition ARM) on a write of 0x55 to the register address.
- ARMED always returns to LOCKED on the next bus write, whatever that write is. If the write is a legal value at the register address, the transition is COMMIT. If it is anything else, the transition is ABORT.
- Every other bus cycle leaves the state unchanged. This is the HOLD transition.

Top module: `memmap_cfg`

## Requirements
- R1: After reset the selection code is 000 and the unlock machine is LOCKED.
- R2: A read with address 0x63 returns the code in bits 2:0 and zeros in bits 7:3, in the same cycle. A read of any other address, or no read, returns 0x00.
- R3: A write of 0x55 to 0x63 followed, as the next bus write, by a write of a legal value to 0x63 stores bits 2:0. The new code is visible right after the clock edge of the second write. A legal value has bits 7:3 zero and a code other than 011 or 111.
- R4: While LOCKED, a write of any value other than 0x55 to 0x63 leaves the code unchanged.
- R5: In ARMED, a bus write to any address other than 0x63 returns the machine to LOCKED. A following value write to 0x63 is then ignored.
- R6: In ARMED, a write to 0x63 whose code is 011 or 111, or whose bits 7:3 are nonzero, is ignored and returns the machine to LOCKED.
- R7: Writing the key 0x55 never changes the stored code.
- R8: The probe flags ROM for these inclusive ranges:
  - code 000: 0x01000–0x1FFFF
  - code 001: 0x02000–0x1FFFF
  - code 010: 0x01000–0x0FFFF
  - code 100: 0x08000–0x0FFFF
  - code 101: 0x0C000–0x0FFFF
  - code 110: 0x08000–0x1FFFF
- R9: The probe flags RAM for 0x00080 up to 0x00FFF for codes 000, 001 and 110, and up to 0x0087F for codes 010, 100 and 101.
- R10: Any probe address outside the ROM and RAM windows is flagged external, and exactly one of the three flags is high at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe, one write per high cycle |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 8 | Bus register address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data, zero unless the register is read |
| sel_code | output | 3 | Stored memory map selection code |
| probe_addr | input | 20 | Physical address to classify |
| probe_rom | output | 1 | Probe address is inside the internal ROM window |
| probe_ram | output | 1 | Probe address is inside the internal RAM window |
| probe_ext | output | 1 | Probe address is external |

## Verification
Read data and probe flags are combinational, so they are due in the same cycle that the read strobe or probe address is driven. A register write takes effect at the clock edge that samples the strobe and is visible from just after that edge. The driver therefore applies every stimulus one time unit after a rising edge and queues the expected value. The monitor pops and compares each queued item at the following falling edge, after any committing edge and before the inputs move again. Ignored writes are checked by reading the register back after the rejected write and before the next write.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    // Unlock sequencing states
    typedef enum logic [0:0] {
        ST_LOCKED = 1'b0,
        ST_ARMED  = 1'b1
    } unlock_st_e;

    localparam int SEL_W = 3;
    typedef logic [SEL_W-1:0] sel_t;

    // Decode result, exactly one bit set
    typedef struct packed {
        logic rom;
        logic ram;
        logic ext;
    } region_t;

    // Codes 011 and 111 are reserved and can never be stored
    function automatic logic sel_legal(input sel_t s);
        return !((s == 3'b011) || (s == 3'b111));
    endfunction

    // Selections that carry the large RAM window
    function automatic logic sel_big_ram(input sel_t s);
        return (s == 3'b000) || (s == 3'b001) || (s == 3'b110);
    endfunction

endpackage

// File: rtl/memmap_unlock_fsm.sv
module memmap_unlock_fsm
    import memmap_pkg::*;
#(
    parameter int              DW       = 8,
    parameter int              RA_W     = 8,
    parameter logic [RA_W-1:0] REG_ADDR = 'h63,
    parameter logic [DW-1:0]   KEY      = 'h55
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [RA_W-1:0] addr,
    input  logic [DW-1:0]   wdata,
    output logic            armed,
    output logic            commit
);

    unlock_st_e state, state_nxt;
    logic       hit;
    logic       upper_clear;

    assign hit         = (addr == REG_ADDR);
    assign upper_clear = (wdata[DW-1:SEL_W] == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nxt;
    end

    // Transitions: ARM, COMMIT/ABORT, HOLD
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_LOCKED: if (wr && hit && (wdata == KEY)) state_nxt = ST_ARMED;
            ST_ARMED:  if (wr)                          state_nxt = ST_LOCKED;
            default:                                    state_nxt = ST_LOCKED;
        endcase
    end

    // Outputs
    always_comb begin
        armed  = 1'b0;
        commit = 1'b0;
        unique case (state)
            ST_LOCKED: begin
                armed  = 1'b0;
                commit = 1'b0;
            end
            ST_ARMED: begin
                armed  = 1'b1;
                commit = wr && hit && upper_clear && sel_legal(wdata[SEL_W-1:0]);
            end
            default: begin
                armed  = 1'b0;
                commit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/memmap_sel_reg.sv
module memmap_sel_reg
    import memmap_pkg::*;
#(
    parameter int              DW       = 8,
    parameter int              RA_W     = 8,
    parameter logic [RA_W-1:0] REG_ADDR = 'h63
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  sel_t            new_sel,
    input  logic            rd,
    input  logic [RA_W-1:0] addr,
    output sel_t            sel,
    output logic [DW-1:0]   rdata
);

    localparam int PAD_W = DW - SEL_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel <= '0;
        else if (commit) sel <= new_sel;
    end

    always_comb begin
        if (rd && (addr == REG_ADDR)) rdata = {{PAD_W{1'b0}}, sel};
        else                          rdata = '0;
    end

endmodule

// File: rtl/memmap_window_decode.sv
module memmap_window_decode
    import memmap_pkg::*;
#(
    parameter int PA_W = 20
) (
    input  sel_t            sel,
    input  logic [PA_W-1:0] paddr,
    output region_t         region
);

    localparam logic [PA_W-1:0] RAM_LO     = PA_W'('h00080);
    localparam logic [PA_W-1:0] RAM_HI_BIG = PA_W'('h00FFF);
    localparam logic [PA_W-1:0] RAM_HI_SML = PA_W'('h0087F);
    localparam logic [PA_W-1:0] TOP_64K    = PA_W'('h0FFFF);
    localparam logic [PA_W-1:0] TOP_128K   = PA_W'('h1FFFF);

    logic [PA_W-1:0] rom_lo, rom_hi, ram_hi;
    logic            rom_en, in_rom, in_ram;

    always_comb begin
        rom_en = 1'b1;
        unique case (sel)
            3'b000:  begin rom_lo = PA_W'('h01000); rom_hi = TOP_128K; end
            3'b001:  begin rom_lo = PA_W'('h02000); rom_hi = TOP_128K; end
            3'b010:  begin rom_lo = PA_W'('h01000); rom_hi = TOP_64K;  end
            3'b100:  begin rom_lo = PA_W'('h08000); rom_hi = TOP_64K;  end
            3'b101:  begin rom_lo = PA_W'('h0C000); rom_hi = TOP_64K;  end
            3'b110:  begin rom_lo = PA_W'('h08000); rom_hi = TOP_128K; end
            default: begin rom_lo = '0; rom_hi = '0; rom_en = 1'b0; end
        endcase
        ram_hi = sel_big_ram(sel) ? RAM_HI_BIG : RAM_HI_SML;
    end

    assign in_rom = rom_en && (paddr >= rom_lo) && (paddr <= rom_hi);
    assign in_ram = (paddr >= RAM_LO) && (paddr <= ram_hi);

    always_comb begin
        region.rom = in_rom;
        region.ram = in_ram && !in_rom;
        region.ext = !in_rom && !in_ram;
    end

endmodule

// File: rtl/memmap_cfg.sv
module memmap_cfg
    import memmap_pkg::*;
#(
    parameter int              DW       = 8,
    parameter int              RA_W     = 8,
    parameter int              PA_W     = 20,
    parameter logic [RA_W-1:0] REG_ADDR = 'h63,
    parameter logic [DW-1:0]   KEY      = 'h55
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [RA_W-1:0] bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [2:0]      sel_code,
    input  logic [PA_W-1:0] probe_addr,
    output logic            probe_rom,
    output logic            probe_ram,
    output logic            probe_ext
);

    logic    key_armed;
    logic    do_commit;
    sel_t    cur_sel;
    region_t region;

    memmap_unlock_fsm #(
        .DW(DW), .RA_W(RA_W), .REG_ADDR(REG_ADDR), .KEY(KEY)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .armed  (key_armed),
        .commit (do_commit)
    );

    memmap_sel_reg #(
        .DW(DW), .RA_W(RA_W), .REG_ADDR(REG_ADDR)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (do_commit),
        .new_sel (bus_wdata[SEL_W-1:0]),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .sel     (cur_sel),
        .rdata   (bus_rdata)
    );

    memmap_window_decode #(
        .PA_W(PA_W)
    ) u_dec (
        .sel    (cur_sel),
        .paddr  (probe_addr),
        .region (region)
    );

    assign sel_code  = cur_sel;
    assign probe_rom = region.rom;
    assign probe_ram = region.ram;
    assign probe_ext = region.ext;

endmodule

// File: rtl/memmap_cfg_chk.sv
module memmap_cfg_chk #(
    parameter int              DW       = 8,
    parameter int              RA_W     = 8,
    parameter int              PA_W     = 20,
    parameter logic [RA_W-1:0] REG_ADDR = 'h63,
    parameter logic [DW-1:0]   KEY      = 'h55
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic [RA_W-1:0] bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic [2:0]      sel_code,
    input logic            key_armed,
    input logic [PA_W-1:0] probe_addr,
    input logic            probe_rom,
    input logic            probe_ram,
    input logic            probe_ext
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sel_code == 3'b000) && !key_armed); // R1

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DW-1:3] == '0); // R2

    AST_LOCKED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !key_armed) |=> $stable(sel_code)); // R4

    AST_KEY_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_wdata == KEY)) |=> $stable(sel_code)); // R7

    AST_ARMED_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && key_armed) |=> !key_armed); // R5

    AST_OTHER_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr != REG_ADDR)) |=> $stable(sel_code)); // R5

    AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_code != 3'b011) && (sel_code != 3'b111)); // R6

    AST_ROM_ABOVE_4K: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_addr < PA_W'('h01000)) |-> !probe_rom); // R8

    AST_RAM_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        probe_ram |-> (probe_addr >= PA_W'('h00080)) && (probe_addr <= PA_W'('h00FFF))); // R9

    AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({probe_rom, probe_ram, probe_ext}) == 1); // R10

endmodule

bind memmap_cfg memmap_cfg_chk #(
    .DW(DW), .RA_W(RA_W), .PA_W(PA_W), .REG_ADDR(REG_ADDR), .KEY(KEY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .sel_code   (sel_code),
    .key_armed  (key_armed),
    .probe_addr (probe_addr),
    .probe_rom  (probe_rom),
    .probe_ram  (probe_ram),
    .probe_ext  (probe_ext)
);

// File: tb/memmap_cfg_tb.sv
`timescale 1ns/1ps
module memmap_cfg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [2:0]  sel_code;
    logic [19:0] probe_addr = '0;
    logic        probe_rom, probe_ram, probe_ext;

    always #10 clk = ~clk; // 50 MHz

    memmap_cfg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sel_code(sel_code), .probe_addr(probe_addr),
        .probe_rom(probe_rom), .probe_ram(probe_ram), .probe_ext(probe_ext)
    );

    typedef struct {
        string      req;
        bit         is_dec;
        logic [7:0] exp;
    } sb_item_t;

    sb_item_t sb_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Monitor: compare one queued expectation per falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            act = it.is_dec ? {5'b0, probe_rom, probe_ram, probe_ext} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s: actual=%02h expected=%02h", it.req, act, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic check_read(input string req, input logic [7:0] a, input logic [7:0] exp);
        sb_item_t it;
        bus_rd = 1'b1; bus_addr = a;
        it.req = req; it.is_dec = 1'b0; it.exp = exp;
        sb_q.push_back(it);
        @(negedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // Reference windows written from R8/R9
    function automatic logic [7:0] region_of(input logic [2:0] c, input logic [19:0] a);
        logic [19:0] lo, hi, rhi;
        logic rom, ram;
        case (c)
            3'b000: begin lo = 20'h01000; hi = 20'h1FFFF; end
            3'b001: begin lo = 20'h02000; hi = 20'h1FFFF; end
            3'b010: begin lo = 20'h01000; hi = 20'h0FFFF; end
            3'b100: begin lo = 20'h08000; hi = 20'h0FFFF; end
            3'b101: begin lo = 20'h0C000; hi = 20'h0FFFF; end
            default: begin lo = 20'h08000; hi = 20'h1FFFF; end
        endcase
        rhi = (c == 3'b010 || c == 3'b100 || c == 3'b101) ? 20'h0087F : 20'h00FFF;
        rom = (a >= lo) && (a <= hi);
        ram = !rom && (a >= 20'h00080) && (a <= rhi);
        return {5'b0, rom, ram, !rom && !ram};
    endfunction

    task automatic check_probe(input string req, input logic [2:0] c, input logic [19:0] a);
        sb_item_t it;
        probe_addr = a;
        it.req = req; it.is_dec = 1'b1; it.exp = region_of(c, a);
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic set_code(input logic [2:0] c);
        bus_write(8'h63, 8'h55);
        bus_write(8'h63, {5'b0, c});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        check_read("R1 reset code", 8'h63, 8'h00);
        check_probe("R1 reset decode", 3'b000, 20'h01000);
        check_read("R2 other address reads zero", 8'h62, 8'h00);

        bus_write(8'h63, 8'h01);
        check_read("R4 unkeyed write ignored", 8'h63, 8'h00);

        bus_write(8'h63, 8'h55);
        check_read("R7 key not stored", 8'h63, 8'h00);
        bus_write(8'h63, 8'h01);
        check_read("R3 keyed write stored", 8'h63, 8'h01);

        bus_write(8'h63, 8'h55);
        bus_write(8'h62, 8'h10);
        bus_write(8'h63, 8'h02);
        check_read("R5 other-address write disarms", 8'h63, 8'h01);

        bus_write(8'h63, 8'h55);
        bus_write(8'h63, 8'h03);
        check_read("R6 reserved 011 ignored", 8'h63, 8'h01);
        bus_write(8'h63, 8'h02);
        check_read("R6 disarmed after reserved", 8'h63, 8'h01);
        bus_write(8'h63, 8'h55);
        bus_write(8'h63, 8'h0A);
        check_read("R6 upper bits set ignored", 8'h63, 8'h01);
        bus_write(8'h63, 8'h55);
        bus_write(8'h63, 8'h07);
        check_read("R6 reserved 111 ignored", 8'h63, 8'h01);

        foreach (u_codes[i]) begin
            logic [2:0] c;
            c = u_codes[i];
            set_code(c);
            check_read("R3 code read back", 8'h63, {5'b0, c});
            check_probe("R9 below RAM external", c, 20'h0007F);
            check_probe("R9 RAM base", c, 20'h00080);
            check_probe("R9 small RAM top", c, 20'h0087F);
            check_probe("R9 above small RAM", c, 20'h00880);
            check_probe("R9 large RAM top", c, 20'h00FFF);
            check_probe("R8 4K boundary", c, 20'h01000);
            check_probe("R8 8K boundary", c, 20'h01FFF);
            check_probe("R8 8K start", c, 20'h02000);
            check_probe("R8 32K edge low", c, 20'h07FFF);
            check_probe("R8 32K start", c, 20'h08000);
            check_probe("R8 48K edge", c, 20'h0BFFF);
            check_probe("R8 48K start", c, 20'h0C000);
            check_probe("R8 64K top", c, 20'h0FFFF);
            check_probe("R8 64K above", c, 20'h10000);
            check_probe("R8 128K top", c, 20'h1FFFF);
            check_probe("R10 above 128K external", c, 20'h20000);
            check_probe("R10 top of space external", c, 20'hFFFFF);
        end

        check_read("R2 no strobe reads zero", 8'h00, 8'h00);

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    logic [2:0] u_codes [6] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110};

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule